// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register

A chain of storage stages that either copies a parallel word into every stage at once or moves its contents one stage toward the far end, taking a new bit in at stage 0. The far-end stage is driven out both true and inverted. When the far-end output of one unit feeds the serial input of the next, the units form a longer parallel-to-serial converter.

The shift clock is not a clock of the design. It is the OR of two interchangeable pins, so either pin can carry clock pulses while the other acts as an active-low enable. The block runs on one fast system clock. It synchronizes the load pin, both clock-side pins and the serial input through two flops each. It shifts when it sees the synchronized OR of the two clock-side pins change from 0 to 1. Load is level-sensitive and takes precedence over shifting.

Top module: `pss_shifter`

## Requirements
- R1: While `loadN` is 0 (seen through the synchronizer), every stage copies `parIn` on every system cycle. Bit i of `parIn` goes to stage i, and no clock-pin edge is needed. The stages keep following changes of `parIn` while the load lasts.
- R2: While `loadN` is 1, each 0-to-1 change of the effective clock moves stage i to stage i+1 and puts `serIn` into stage 0, exactly once per rising change, however long the clock stays high.
- R3: `lastOut` equals stage STAGES-1 and `lastOutN` is always its complement.
- R4: The effective clock is `clkPin` OR `enPin`. While `enPin` is 1, toggling `clkPin` causes no shift.
- R5: The two pins are interchangeable. With `clkPin` held at 0, a low-then-high pulse on `enPin` causes one shift.
- R6: Effective-clock rising changes that occur while the load is active are ignored. They leave no shift behind after the load is released.
- R7: A synchronous active-high `rst` clears all stages to 0 and presets the edge history to "high", so the first sample after reset cannot start a shift.
- R8: Two units chained (far-end output to serial input) and loaded with bytes A (upstream) and B shift out B[7]..B[0] and then A[7]..A[0], followed by the bits fed to the upstream serial input.
- R9: A change of `loadN`, `clkPin` or `enPin` presented before system edge k affects the stages at system edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| loadN | input | 1 | Parallel load, active low, asynchronous to clk |
| clkPin | input | 1 | Clock-side pin A, ORed with enPin |
| enPin | input | 1 | Clock-side pin B, ORed with clkPin |
| serIn | input | 1 | Serial data into stage 0 |
| parIn | input | STAGES | Parallel data, bit i to stage i |
| lastOut | output | 1 | Far-end stage |
| lastOutN | output | 1 | Complement of the far-end stage |

## Verification
A load and a rising edge of the effective clock can arrive in the same system cycle. The bench provokes this by pulsing `clkPin` several times while `loadN` is held low and `parIn` is being changed. It then releases the load and checks that the far-end output still shows the loaded most-significant bit and that the following 16-bit stream begins at that bit. An overlap handled wrongly shows up as a missing leading bit or as a word shifted by one place.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef struct packed {
    logic loadNow;
    logic shiftNow;
  } shiftCtrl_t;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] metaQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      metaQ   <= RESET_VAL;
      syncOut <= RESET_VAL;
    end else begin
      metaQ   <= asyncIn;
      syncOut <= metaQ;
    end
  end
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       loadN,
  input  logic       clkPin,
  input  logic       enPin,
  input  logic       serIn,
  output shiftCtrl_t strobes,
  output logic       serBit
);
  logic [2:0] pinSync;
  logic       loadS, clkS, enS, combNow, combPrev;

  // Reset value 1 for all three: load idle, effective clock parked high.
  pss_sync #(.WIDTH(3), .RESET_VAL(3'b111)) pinSync_i (
    .clk(clk), .rst(rst),
    .asyncIn({loadN, clkPin, enPin}),
    .syncOut(pinSync)
  );

  pss_sync #(.WIDTH(1), .RESET_VAL(1'b0)) serSync_i (
    .clk(clk), .rst(rst), .asyncIn(serIn), .syncOut(serBit)
  );

  assign {loadS, clkS, enS} = pinSync;
  assign combNow = clkS | enS;

  always_ff @(posedge clk) begin
    if (rst) combPrev <= 1'b1;
    else     combPrev <= combNow;
  end

  always_comb begin
    strobes.loadNow  = ~loadS;
    strobes.shiftNow = loadS & combNow & ~combPrev;
  end

  // R2: one shift per rising change, never two cycles in a row
  p_single_shift_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftNow |=> !strobes.shiftNow);

  // R4: enable held high over two samples blocks any shift
  p_enable_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (enS && $past(enS)) |-> !strobes.shiftNow);
endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  shiftCtrl_t        strobes,
  input  logic [STAGES-1:0] parIn,
  input  logic              serBit,
  output logic [STAGES-1:0] stages
);
  always_ff @(posedge clk) begin
    if (rst)                   stages <= '0;
    else if (strobes.loadNow)  stages <= parIn;
    else if (strobes.shiftNow) stages <= {stages[STAGES-2:0], serBit};
  end

  p_load_track_r1: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.loadNow) |-> stages == $past(parIn));

  p_shift_order_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(strobes.shiftNow) && !$past(strobes.loadNow))
      |-> stages == {$past(stages[STAGES-2:0]), $past(serBit)});

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(strobes.shiftNow) && !$past(strobes.loadNow)) |-> $stable(stages));

  p_reset_clear_r7: assert property (@(posedge clk)
    $past(rst) |-> stages == '0);
endmodule

// File: rtl/pss_shifter.sv
module pss_shifter
  import pss_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadN,
  input  logic              clkPin,
  input  logic              enPin,
  input  logic              serIn,
  input  logic [STAGES-1:0] parIn,
  output logic              lastOut,
  output logic              lastOutN
);
  localparam int LAST = STAGES - 1;

  shiftCtrl_t        strobes;
  logic              serBit;
  logic [STAGES-1:0] stages;

  pss_ctrl ctrl_i (
    .clk(clk), .rst(rst), .loadN(loadN), .clkPin(clkPin), .enPin(enPin),
    .serIn(serIn), .strobes(strobes), .serBit(serBit)
  );

  pss_datapath #(.STAGES(STAGES)) data_i (
    .clk(clk), .rst(rst), .strobes(strobes), .parIn(parIn),
    .serBit(serBit), .stages(stages)
  );

  assign lastOut  = stages[LAST];
  assign lastOutN = ~stages[LAST];
endmodule

// File: tb/pss_shifter_tb.sv
module pss_shifter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadN = 1'b1, clkPin = 1'b1, enPin = 1'b0, serInTb = 1'b0;
  logic [7:0] parA = '0, parB = '0;
  logic chainBit, upN, lastOut, lastOutN;
  int checks = 0, failures = 0;
  bit finished = 0;
  logic expQ[$];
  string curTag;
  event sampleEv;

  always #10 clk = ~clk;

  pss_shifter #(.STAGES(8)) upInst (
    .clk(clk), .rst(rst), .loadN(loadN), .clkPin(clkPin), .enPin(enPin),
    .serIn(serInTb), .parIn(parA), .lastOut(chainBit), .lastOutN(upN)
  );

  pss_shifter #(.STAGES(8)) dut_i (
    .clk(clk), .rst(rst), .loadN(loadN), .clkPin(clkPin), .enPin(enPin),
    .serIn(chainBit), .parIn(parB), .lastOut(lastOut), .lastOutN(lastOutN)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected far-end bit and compares both outputs
  always begin
    @(sampleEv);
    begin
      logic e;
      e = expQ.pop_front();
      check({curTag, " lastOut"}, lastOut, e);
      check({"R3 ", curTag, " lastOutN"}, lastOutN, ~e);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectBit(string tag, logic b);
    expQ.push_back(b);
    curTag = tag;
    ->sampleEv;
    #1;
  endtask

  task automatic pulseClk();
    clkPin = 1'b0; tick(3);
    clkPin = 1'b1; tick(4);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] serPat = 8'b1011_0010;
    logic [15:0] word;
    tick(3);
    rst = 1'b0;
    tick(2);
    expectBit("R7 reset clear", 1'b0);

    // R9 latency of load, R1 load without clock edge
    parA = 8'h3C; parB = 8'hA5; loadN = 1'b0;
    tick(2);
    expectBit("R9 before latency", 1'b0);
    tick(1);
    expectBit("R9 R1 load seen", 1'b1);

    // R1 tracking while load stays low
    parB = 8'h25; tick(2);
    expectBit("R1 tracking", 1'b0);

    // R6 clock edges during load are ignored
    parB = 8'hC3;
    pulseClk(); pulseClk(); pulseClk();
    loadN = 1'b1; tick(4);
    expectBit("R6 load priority", 1'b1);

    // R8 / R2 chained stream
    word = {parB, parA};
    for (int k = 1; k < 16; k++) begin
      serInTb = (k <= 8) ? serPat[8-k] : 1'b0;
      pulseClk();
      expectBit("R8 R2 stream", word[15-k]);
    end
    serInTb = 1'b0;
    pulseClk();
    expectBit("R8 serial tail", serPat[7]);

    // R4 enable high blocks shifting
    enPin = 1'b1; tick(4);
    pulseClk(); pulseClk(); pulseClk();
    expectBit("R4 enable blocks", serPat[7]);

    // R5 enable pin used as clock
    clkPin = 1'b0; tick(4);
    enPin = 1'b0; tick(3);
    enPin = 1'b1; tick(4);
    expectBit("R5 pins swapped", serPat[6]);

    // R7 reset while effective clock high, then hold
    clkPin = 1'b1; rst = 1'b1; tick(2);
    rst = 1'b0; tick(6);
    expectBit("R7 after reset", 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule